// File: doc/BRIEF.md
# Dynamic Bank-Set Cache Controller

This block runs one bank-set of a distributed last-level cache. Any bank in the set may hold a block. Each requesting core has its own notion of distance to the banks. A request is first sent to the single bank closest to the requester. If that probe misses, every other bank of the set is probed at once. A hit in a farther bank moves the block one step nearer to the requester, so a block that is used often ends up in the bank next to that core. A request that misses in every bank reads the block from memory and installs it in the requester's closest bank. Any valid block displaced by that install goes straight to memory as a write-back.

Each bank is a small set-associative tag store. A probe of any bank takes a fixed number of cycles. Memory reads and write-backs use plain request/response signals. The controller works on one request at a time.

Top module: `dnb_ctrl`

## Requirements
- R1: A request is taken only when the bank-set field `req_addr[IDX_W+BSET_W-1:IDX_W]` (bits [3:2] by default, below it the line index in bits [1:0], above it the tag) equals `MY_SET`. Any other request is ignored: no probe, no memory read, no response, and `req_ready` stays 1.
- R2: After acceptance, only the closest bank is probed (`probe_mask` one-hot) for `PROBE_LAT` cycles. A hit there gives `rsp_valid` with `rsp_hit`=1 and `rsp_bank` = that bank, `PROBE_LAT` cycles after the acceptance edge.
- R3: If the closest bank misses, all other banks are probed together (`probe_mask` = every bank except the closest) for another `PROBE_LAT` cycles. A hit there responds 2*`PROBE_LAT` cycles after acceptance.
- R4: A hit in the bank at distance rank r≥1 moves the block into the bank at rank r-1. `rsp_bank` reports that bank. Repeated requests therefore bring the block to rank 0, one step per request.
- R5: The way chosen in a target bank is the lowest invalid way, or else the way named by a per-line rotating pointer. The pointer advances whenever a valid way is replaced. A migration swaps blocks: the block displaced from the target way moves into the way the migrating block left. If the target way was empty, the source way becomes empty.
- R6: A miss in every bank holds `mem_rd_valid` high with `mem_rd_addr` = request address until `mem_rd_done`. The block is then placed in the closest bank, and the next cycle gives `rsp_hit`=0 with `rsp_bank` = closest bank.
- R7: If the fill replaces a valid block, `wb_valid` pulses with that block's address in the same cycle as the miss response. The evicted block is held in no other bank afterwards.
- R8: `req_ready` is 0 from the acceptance edge until the response cycle, so no second request is taken while a search, migration or fill is in progress.
- R9: After reset every bank is empty, all pointers are 0, `req_ready`=1, and `rsp_valid`, `wb_valid`, `mem_rd_valid` and `probe_mask` are 0.
- R10: For core c, the bank at distance rank r is (c + r) mod `NUM_BANKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_core | input | CORE_W | Requesting core |
| req_addr | input | ADDR_W | Block address |
| rsp_valid | output | 1 | Request finished (one cycle) |
| rsp_hit | output | 1 | 1 = found in a bank, 0 = fetched from memory |
| rsp_bank | output | BANK_W | Bank holding the block after the request |
| probe_mask | output | NUM_BANKS | Banks being probed this cycle |
| mem_rd_valid | output | 1 | Memory read outstanding |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_done | input | 1 | Memory read data returned |
| wb_valid | output | 1 | Evicted block write-back (one cycle) |
| wb_addr | output | ADDR_W | Address of evicted block |

## Verification
Two events can fall in the same cycle. A fill into a full closest bank produces the miss response and the write-back of the evicted block together. The bench forces this by installing a third block at one line index of a two-way bank, and later by re-fetching the evicted block. In that response cycle it checks `rsp_valid`, `rsp_hit`, `rsp_bank`, `wb_valid` and `wb_addr` as one sample. The same re-fetch must go to memory, which shows the evicted block was not kept in a farther bank. Migration updates two banks on the same edge. The bench checks this through later requests from two different cores: each must hit in its own closest bank, with the single-probe latency.

// File: rtl/dnb_pkg.sv
package dnb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_NEAR = 2'd1,
      ST_FAR  = 2'd2,
      ST_MEM  = 2'd3
   } dnb_state_e;

   // distance ordering: bank sitting at a given rank for a given core
   function automatic int unsigned dnb_bank_of(input int unsigned core,
                                               input int unsigned rank,
                                               input int unsigned nbanks);
      return (core + rank) % nbanks;
   endfunction

endpackage

// File: rtl/dnb_timer.sv
module dnb_timer #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("dnb_timer: LAT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= CW'(LAT - 1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LAT - 1));

endmodule

// File: rtl/dnb_bank.sv
module dnb_bank #(
   parameter int TAG_W = 8,
   parameter int LINES = 4,
   parameter int WAYS  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [((LINES>1)?$clog2(LINES):1)-1:0] rd_idx,
   input  logic [TAG_W-1:0]    cmp_tag,
   input  logic                wr_en,
   input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0]   wr_way,
   input  logic [TAG_W-1:0]    wr_tag,
   input  logic                wr_valid,
   input  logic                adv_ptr,
   output logic                hit,
   output logic [((WAYS>1)?$clog2(WAYS):1)-1:0]   hit_way,
   output logic [((WAYS>1)?$clog2(WAYS):1)-1:0]   vic_way,
   output logic                vic_valid,
   output logic [TAG_W-1:0]    vic_tag
);
   localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   generate
      if (WAYS < 1 || TAG_W < 1 || LINES < 1) begin : g_bad_geom
         $error("dnb_bank: illegal geometry");
      end
   endgenerate

   logic [TAG_W-1:0] tag_q [LINES][WAYS];
   logic [WAYS-1:0]  val_q [LINES];
   logic [WAY_W-1:0] ptr_q [LINES];

   logic [WAYS-1:0]  line_val;
   logic [WAY_W-1:0] line_ptr;

   assign line_val = val_q[rd_idx];
   assign line_ptr = ptr_q[rd_idx];

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (line_val[w] && tag_q[rd_idx][w] == cmp_tag) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      end
   end

   generate
      if (WAYS == 1) begin : g_vic_direct
         assign vic_way = '0;
      end else begin : g_vic_search
         always_comb begin
            vic_way = line_ptr;
            for (int w = WAYS - 1; w >= 0; w--) begin
               if (!line_val[w]) vic_way = WAY_W'(w);
            end
         end
      end
   endgenerate

   assign vic_valid = line_val[vic_way];
   assign vic_tag   = tag_q[rd_idx][vic_way];

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[rd_idx][wr_way] <= wr_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) begin
            val_q[l] <= '0;
            ptr_q[l] <= '0;
         end
      end else begin
         if (wr_en) val_q[rd_idx][wr_way] <= wr_valid;
         if (adv_ptr)
            ptr_q[rd_idx] <= (line_ptr == WAY_W'(WAYS - 1)) ? '0 : line_ptr + 1'b1;
      end
   end

   logic dup_tag;
   always_comb begin
      dup_tag = 1'b0;
      for (int i = 0; i < WAYS; i++) begin
         for (int j = i + 1; j < WAYS; j++) begin
            if (line_val[i] && line_val[j] && tag_q[rd_idx][i] == tag_q[rd_idx][j])
               dup_tag = 1'b1;
         end
      end
   end

   // R5
   uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_tag);

   // R5
   ptr_adv_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_ptr |-> (&line_val));

endmodule

// File: rtl/dnb_pick.sv
module dnb_pick
   import dnb_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int NUM_CORES = 4
) (
   input  logic [((NUM_CORES>1)?$clog2(NUM_CORES):1)-1:0] core,
   input  logic [NUM_BANKS-1:0]        hit_vec,
   output logic                        far_hit,
   output logic [$clog2(NUM_BANKS)-1:0] far_bank,
   output logic [$clog2(NUM_BANKS)-1:0] tgt_bank
);
   localparam int BANK_W = $clog2(NUM_BANKS);

   always_comb begin
      far_hit  = 1'b0;
      far_bank = '0;
      tgt_bank = '0;
      for (int r = NUM_BANKS - 1; r >= 1; r--) begin
         if (hit_vec[dnb_bank_of(int'(core), r, NUM_BANKS)]) begin
            far_hit  = 1'b1;
            far_bank = BANK_W'(dnb_bank_of(int'(core), r, NUM_BANKS));
            tgt_bank = BANK_W'(dnb_bank_of(int'(core), r - 1, NUM_BANKS));
         end
      end
   end

endmodule

// File: rtl/dnb_ctrl.sv
module dnb_ctrl
   import dnb_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_BANKS = 4,
   parameter int NUM_WAYS  = 2,
   parameter int LINES     = 4,
   parameter int BSET_W    = 2,
   parameter int MY_SET    = 1,
   parameter int NUM_CORES = 4,
   parameter int PROBE_LAT = 2
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       req_valid,
   output logic                                       req_ready,
   input  logic [((NUM_CORES>1)?$clog2(NUM_CORES):1)-1:0] req_core,
   input  logic [ADDR_W-1:0]                          req_addr,
   output logic                                       rsp_valid,
   output logic                                       rsp_hit,
   output logic [$clog2(NUM_BANKS)-1:0]               rsp_bank,
   output logic [NUM_BANKS-1:0]                       probe_mask,
   output logic                                       mem_rd_valid,
   output logic [ADDR_W-1:0]                          mem_rd_addr,
   input  logic                                       mem_rd_done,
   output logic                                       wb_valid,
   output logic [ADDR_W-1:0]                          wb_addr
);
   localparam int BANK_W = $clog2(NUM_BANKS);
   localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1;
   localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
   localparam int TAG_W  = ADDR_W - IDX_W - BSET_W;

   generate
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $error("dnb_ctrl: NUM_BANKS must be a power of two, at least 2");
      end
      if ((1 << IDX_W) != LINES) begin : g_bad_lines
         $error("dnb_ctrl: LINES must be a power of two");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("dnb_ctrl: ADDR_W too small for index and set fields");
      end
      if (MY_SET >= (1 << BSET_W)) begin : g_bad_set
         $error("dnb_ctrl: MY_SET does not fit the set field");
      end
   endgenerate

   dnb_state_e        state_q;
   logic [CORE_W-1:0] core_q;
   logic [ADDR_W-1:0] addr_q;

   logic [IDX_W-1:0]  cur_idx;
   logic [TAG_W-1:0]  cur_tag;
   assign cur_idx = addr_q[IDX_W-1:0];
   assign cur_tag = addr_q[ADDR_W-1 -: TAG_W];

   logic [BANK_W-1:0] near_bank;
   assign near_bank = BANK_W'(dnb_bank_of(int'(core_q), 0, NUM_BANKS));

   logic accept;
   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid &&
                      (req_addr[IDX_W +: BSET_W] == BSET_W'(MY_SET));

   // bank array
   logic [NUM_BANKS-1:0] b_hit, b_vic_valid;
   logic [WAY_W-1:0]     b_hit_way [NUM_BANKS];
   logic [WAY_W-1:0]     b_vic_way [NUM_BANKS];
   logic [TAG_W-1:0]     b_vic_tag [NUM_BANKS];
   logic [NUM_BANKS-1:0] w_en, w_valid, w_adv;
   logic [WAY_W-1:0]     w_way [NUM_BANKS];
   logic [TAG_W-1:0]     w_tag [NUM_BANKS];

   generate
      for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
         dnb_bank #(
            .TAG_W (TAG_W),
            .LINES (LINES),
            .WAYS  (NUM_WAYS)
         ) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (cur_idx),
            .cmp_tag   (cur_tag),
            .wr_en     (w_en[gb]),
            .wr_way    (w_way[gb]),
            .wr_tag    (w_tag[gb]),
            .wr_valid  (w_valid[gb]),
            .adv_ptr   (w_adv[gb]),
            .hit       (b_hit[gb]),
            .hit_way   (b_hit_way[gb]),
            .vic_way   (b_vic_way[gb]),
            .vic_valid (b_vic_valid[gb]),
            .vic_tag   (b_vic_tag[gb])
         );
      end
   endgenerate

   logic              far_hit;
   logic [BANK_W-1:0] far_bank, tgt_bank;

   dnb_pick #(
      .NUM_BANKS (NUM_BANKS),
      .NUM_CORES (NUM_CORES)
   ) i_pick (
      .core     (core_q),
      .hit_vec  (b_hit),
      .far_hit  (far_hit),
      .far_bank (far_bank),
      .tgt_bank (tgt_bank)
   );

   logic near_hit, t_done, t_load;
   assign near_hit = b_hit[near_bank];
   assign t_load   = accept || (state_q == ST_NEAR && t_done && !near_hit);

   dnb_timer #(.LAT(PROBE_LAT)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (t_load),
      .done  (t_done)
   );

   logic do_mig, do_fill;
   assign do_mig  = (state_q == ST_FAR) && t_done && far_hit;
   assign do_fill = (state_q == ST_MEM) && mem_rd_done;

   always_comb begin
      w_en    = '0;
      w_valid = '0;
      w_adv   = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         w_way[b] = '0;
         w_tag[b] = '0;
         if (do_mig && BANK_W'(b) == tgt_bank) begin
            w_en[b]    = 1'b1;
            w_way[b]   = b_vic_way[b];
            w_tag[b]   = cur_tag;
            w_valid[b] = 1'b1;
            w_adv[b]   = b_vic_valid[b];
         end
         if (do_mig && BANK_W'(b) == far_bank) begin
            w_en[b]    = 1'b1;
            w_way[b]   = b_hit_way[b];
            w_tag[b]   = b_vic_tag[tgt_bank];
            w_valid[b] = b_vic_valid[tgt_bank];
         end
         if (do_fill && BANK_W'(b) == near_bank) begin
            w_en[b]    = 1'b1;
            w_way[b]   = b_vic_way[b];
            w_tag[b]   = cur_tag;
            w_valid[b] = 1'b1;
            w_adv[b]   = b_vic_valid[b];
         end
      end
   end

   logic              rsp_valid_q, rsp_hit_q, wb_valid_q;
   logic [BANK_W-1:0] rsp_bank_q;
   logic [ADDR_W-1:0] wb_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         core_q      <= '0;
         addr_q      <= '0;
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         rsp_bank_q  <= '0;
         wb_valid_q  <= 1'b0;
         wb_addr_q   <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         wb_valid_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_NEAR;
               core_q  <= req_core;
               addr_q  <= req_addr;
            end
            ST_NEAR: if (t_done) begin
               if (near_hit) begin
                  state_q     <= ST_IDLE;
                  rsp_valid_q <= 1'b1;
                  rsp_hit_q   <= 1'b1;
                  rsp_bank_q  <= near_bank;
               end else begin
                  state_q <= ST_FAR;
               end
            end
            ST_FAR: if (t_done) begin
               if (far_hit) begin
                  state_q     <= ST_IDLE;
                  rsp_valid_q <= 1'b1;
                  rsp_hit_q   <= 1'b1;
                  rsp_bank_q  <= tgt_bank;
               end else begin
                  state_q <= ST_MEM;
               end
            end
            ST_MEM: if (mem_rd_done) begin
               state_q     <= ST_IDLE;
               rsp_valid_q <= 1'b1;
               rsp_hit_q   <= 1'b0;
               rsp_bank_q  <= near_bank;
               wb_valid_q  <= b_vic_valid[near_bank];
               wb_addr_q   <= {b_vic_tag[near_bank], BSET_W'(MY_SET), cur_idx};
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid    = rsp_valid_q;
   assign rsp_hit      = rsp_hit_q;
   assign rsp_bank     = rsp_bank_q;
   assign wb_valid     = wb_valid_q;
   assign wb_addr      = wb_addr_q;
   assign mem_rd_valid = (state_q == ST_MEM);
   assign mem_rd_addr  = addr_q;

   always_comb begin
      probe_mask = '0;
      if (state_q == ST_NEAR)     probe_mask[near_bank] = 1'b1;
      else if (state_q == ST_FAR) begin
         probe_mask = '1;
         probe_mask[near_bank] = 1'b0;
      end
   end

   // R8
   rsp_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(state_q != ST_IDLE));

   // R6
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_done) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   // R7
   wb_with_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (rsp_valid && !rsp_hit));

   // R3
   probe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_mask != '0) |-> !req_ready);

   // R2
   probe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(probe_mask) == 0 || $countones(probe_mask) == 1 ||
       $countones(probe_mask) == NUM_BANKS - 1));

endmodule

// File: tb/test_dnb_ctrl.sv
`timescale 1ns/1ps
module test_dnb_ctrl;
   localparam int L = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_core = '0;
   logic [11:0] req_addr = '0;
   logic        rsp_valid, rsp_hit;
   logic [1:0]  rsp_bank;
   logic [3:0]  probe_mask;
   logic        mem_rd_valid;
   logic [11:0] mem_rd_addr;
   logic        mem_rd_done = 1'b0;
   logic        wb_valid;
   logic [11:0] wb_addr;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   dnb_ctrl i_dnb_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_core     (req_core),
      .req_addr     (req_addr),
      .rsp_valid    (rsp_valid),
      .rsp_hit      (rsp_hit),
      .rsp_bank     (rsp_bank),
      .probe_mask   (probe_mask),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rd_done  (mem_rd_done),
      .wb_valid     (wb_valid),
      .wb_addr      (wb_addr)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // one request; expectations given by hand from the requirements
   task automatic do_req(input int core, input logic [11:0] addr,
                         input bit exp_hit, input int exp_bank, input int exp_lat,
                         input bit exp_wb, input logic [11:0] exp_wb_addr,
                         input string rq);
      int n;
      logic [3:0] near_m;
      near_m = 4'b0001 << (core % 4);
      @(negedge clk);
      chk(req_ready == 1'b1, "R8", "ready before request", int'(req_ready), 1);
      req_valid = 1'b1;
      req_core  = 2'(core);
      req_addr  = addr;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      chk(probe_mask == near_m, "R2", "unicast probe mask", int'(probe_mask), int'(near_m));
      chk(req_ready == 1'b0, "R8", "ready during search", int'(req_ready), 0);
      while (!rsp_valid && n < 60) begin
         if (mem_rd_valid) begin
            chk(exp_lat < 0, rq, "unexpected memory read", 1, 0);
            chk(mem_rd_addr == addr, "R6", "memory read address", int'(mem_rd_addr), int'(addr));
            mem_rd_done = 1'b1;
         end
         @(negedge clk);
         mem_rd_done = 1'b0;
         n++;
         if (n == L && !rsp_valid)
            chk(probe_mask == (~near_m & 4'hF), "R3", "broadcast probe mask",
                int'(probe_mask), int'(~near_m & 4'hF));
         if (!rsp_valid)
            chk(req_ready == 1'b0, "R8", "ready while busy", int'(req_ready), 0);
      end
      chk(rsp_valid == 1'b1, rq, "response seen", int'(rsp_valid), 1);
      chk(rsp_hit == exp_hit, rq, "rsp_hit", int'(rsp_hit), int'(exp_hit));
      chk(int'(rsp_bank) == exp_bank, rq, "rsp_bank", int'(rsp_bank), exp_bank);
      if (exp_lat >= 0) chk(n == exp_lat, rq, "latency", n, exp_lat);
      chk(wb_valid == exp_wb, "R7", "wb_valid at response", int'(wb_valid), int'(exp_wb));
      if (exp_wb) chk(wb_addr == exp_wb_addr, "R7", "wb_addr", int'(wb_addr), int'(exp_wb_addr));
      @(negedge clk);
      chk(rsp_valid == 1'b0 && wb_valid == 1'b0, rq, "single-cycle response",
          int'({rsp_valid, wb_valid}), 0);
   endtask

   task automatic t_reset;
      chk(req_ready == 1'b1, "R9", "req_ready", int'(req_ready), 1);
      chk(rsp_valid == 1'b0, "R9", "rsp_valid", int'(rsp_valid), 0);
      chk(wb_valid == 1'b0, "R9", "wb_valid", int'(wb_valid), 0);
      chk(mem_rd_valid == 1'b0, "R9", "mem_rd_valid", int'(mem_rd_valid), 0);
      chk(probe_mask == 4'h0, "R9", "probe_mask", int'(probe_mask), 0);
   endtask

   task automatic t_wrong_set;
      @(negedge clk);
      req_valid = 1'b1;
      req_core  = 2'd0;
      req_addr  = 12'h019;   // set field = 2
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(req_ready && !rsp_valid && !mem_rd_valid && probe_mask == 4'h0, "R1",
             "foreign set ignored",
             int'({req_ready, rsp_valid, mem_rd_valid, probe_mask}), 32'h40);
      end
      req_valid = 1'b0;
   endtask

   task automatic t_migrate;
      // R6 fill by core 0 into its closest bank 0
      do_req(0, 12'h015, 1'b0, 0, -1, 1'b0, 12'h0, "R6");
      do_req(0, 12'h015, 1'b1, 0, L, 1'b0, 12'h0, "R2");
      // R10 core 2: ranks 2,3,0,1; block at rank 2 moves to bank 3, then 2
      do_req(2, 12'h015, 1'b1, 3, 2*L, 1'b0, 12'h0, "R4");
      do_req(2, 12'h015, 1'b1, 2, 2*L, 1'b0, 12'h0, "R4");
      do_req(2, 12'h015, 1'b1, 2, L, 1'b0, 12'h0, "R4");
      // R5 emptied source: core 0 misses bank 0, finds rank 2 (bank 2), moves to bank 1
      do_req(0, 12'h015, 1'b1, 1, 2*L, 1'b0, 12'h0, "R10");
   endtask

   task automatic t_evict;
      do_req(1, 12'h024, 1'b0, 1, -1, 1'b0, 12'h0, "R6");
      do_req(1, 12'h034, 1'b0, 1, -1, 1'b0, 12'h0, "R6");
      do_req(1, 12'h044, 1'b0, 1, -1, 1'b1, 12'h024, "R7");
      // evicted block is nowhere in the set: full miss, evicts way 1
      do_req(1, 12'h024, 1'b0, 1, -1, 1'b1, 12'h034, "R7");
      do_req(1, 12'h044, 1'b1, 1, L, 1'b0, 12'h0, "R7");
   endtask

   task automatic t_swap;
      do_req(0, 12'h056, 1'b0, 0, -1, 1'b0, 12'h0, "R5");
      do_req(0, 12'h066, 1'b0, 0, -1, 1'b0, 12'h0, "R5");
      do_req(3, 12'h076, 1'b0, 3, -1, 1'b0, 12'h0, "R5");
      do_req(3, 12'h086, 1'b0, 3, -1, 1'b0, 12'h0, "R5");
      // core 3 hits in bank 0 (rank 1): swap with way 0 of full bank 3
      do_req(3, 12'h056, 1'b1, 3, 2*L, 1'b0, 12'h0, "R5");
      do_req(0, 12'h076, 1'b1, 0, L, 1'b0, 12'h0, "R5");
      do_req(3, 12'h056, 1'b1, 3, L, 1'b0, 12'h0, "R5");
      do_req(3, 12'h086, 1'b1, 3, L, 1'b0, 12'h0, "R5");
      do_req(0, 12'h066, 1'b1, 0, L, 1'b0, 12'h0, "R5");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wrong_set();
      t_migrate();
      t_evict();
      t_swap();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule